// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor as two outputs: a normal request line and a fast request line. Each output is fed by its own routing bank. A bank has its own source mask, its own latched-pending store, its own priority threshold and its own service readout. The bank reports the number of the single source to service next. Software reaches every register through a plain 32-bit register bus with a 12-bit byte address. Reads complete in the same cycle and writes take effect at the clock edge.

Three settings are shared by both banks and apply to each source. The first is a polarity select, where a 1 passes the line unchanged and a 0 inverts it. The second is a capture mode, either latched until acknowledged or followed as a level. The third is a 4-bit priority. Reading a bank's acknowledge register returns that bank's latched sources and then clears them. Sources that are still asserted at that edge latch again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Bank base is 0x000 for the normal bank and 0x100 for the fast bank. Writing to offset 0x08 sets the mask bits where the write data has ones. Writing to offset 0x0C clears the mask bits where the write data has ones. Zero data bits leave the mask unchanged. Reading 0x08 returns the mask, and reading 0x0C returns zero.
- R2: The word at 0x200 selects polarity per source: 1 passes the line unchanged and 0 inverts it. This word resets to all ones. Bank offset 0x04 reads the 32 lines after polarity selection and before masking.
- R3: The word at 0x204 selects capture per source: 1 latches the source and 0 follows the level. This word resets to zero. A latched source stays pending after its line drops.
- R4: A read of bank offset 0x28 returns that bank's latch contents. At that edge it clears all of that bank's latches and leaves the other bank's latches unchanged. A latched-mode source that is asserted at that same edge stays latched.
- R5: Bank offset 0x00 reads the bit vector of sources that are pending, unmasked in that bank, and have a priority value less than or equal to that bank's threshold.
- R6: Bank offset 0x20 reads the number of the source with the lowest priority value among the bits of R5. Ties go to the lowest source number. The readout is 0 when no bit of R5 is set.
- R7: Bank offset 0x2C holds the 4-bit threshold in bits 3:0 and resets to 0xF. The value 0xF admits every priority.
- R8: Source n's priority sits at 0x300 + 4*n, in bits 3:0. Value 0 is the most urgent. All priorities reset to 0.
- R9: irq_o goes high one clock after the normal bank's R5 vector becomes nonzero, and fiq_o does the same for the fast bank. Each goes low one clock after its vector becomes zero.
- R10: After reset, both masks and all latches are zero, all priorities are zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt request lines |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The case most likely to go wrong is an acknowledge read of a bank that lands in the same cycle as a latched-mode source that is still asserted. The clear and the re-capture then act on one latch bit at one edge. The bench holds the line high through the acknowledge read and reads status in the next cycle, where the bit must still be set. It then drops the line and acknowledges again, after which the bit must be clear. Random traffic also makes mask writes coincide with line changes, and every cycle is judged against a behavioural model of both banks.

// File: rtl/ivc_pkg.sv
// Package: register offsets shared by the controller's modules.
// Assumes a 12-bit byte address with word-aligned registers.
package ivc_pkg;
    localparam logic [7:0] OFS_STATUS = 8'h00;
    localparam logic [7:0] OFS_RAW    = 8'h04;
    localparam logic [7:0] OFS_SET    = 8'h08;
    localparam logic [7:0] OFS_CLR    = 8'h0C;
    localparam logic [7:0] OFS_CUR    = 8'h20;
    localparam logic [7:0] OFS_ACK    = 8'h28;
    localparam logic [7:0] OFS_THR    = 8'h2C;
    localparam logic [11:0] ADR_POL    = 12'h200;
    localparam logic [11:0] ADR_CAP    = 12'h204;
    localparam logic [3:0]  PAGE_PRIO  = 4'h3;
    localparam int unsigned NUM_BANKS  = 2;
endpackage

// File: rtl/ivc_arbiter.sv
// Module: picks the eligible source with the lowest priority value.
// Ties go to the lowest index. Returns index 0 when nothing is eligible.
// Purely combinational, one linear scan over N_SRC entries.
module ivc_arbiter #(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             elig_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic [IW-1:0]                win_o
);
    logic [PRIO_W-1:0] best;

    // Scan from the top down so that an equal value at a lower index replaces the previous winner.
    always_comb begin
        best  = '1;
        win_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (prio_i[i] <= best)) begin
                best  = prio_i[i];
                win_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ivc_bank.sv
// Module: one routing bank, with mask, latches, threshold, winner and registered request.
// Assumes the polarity-corrected lines and the shared controls come from the top.
module ivc_bank #(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned IW    = $clog2(N_SRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             line_i,
    input  logic [N_SRC-1:0]             cap_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic                         set_we_i,
    input  logic                         clr_we_i,
    input  logic                         thr_we_i,
    input  logic                         ack_re_i,
    input  logic [N_SRC-1:0]             wdata_i,
    input  logic [PRIO_W-1:0]            thr_wdata_i,
    output logic [N_SRC-1:0]             mask_o,
    output logic [N_SRC-1:0]             latch_o,
    output logic [PRIO_W-1:0]            thr_o,
    output logic [N_SRC-1:0]             status_o,
    output logic [IW-1:0]                cur_o,
    output logic                         req_o
);
    logic [N_SRC-1:0] pending;
    logic [N_SRC-1:0] admit;

    // Mask update: set-ones and clear-ones writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_o <= '0;
        else if (set_we_i) mask_o <= mask_o | wdata_i;
        else if (clr_we_i) mask_o <= mask_o & ~wdata_i;
    end

    // Latch update: acknowledge clears, and a still-asserted latched-mode line wins.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_o <= '0;
        else        latch_o <= (latch_o & ~{N_SRC{ack_re_i}}) | (line_i & cap_i);
    end

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_o <= '1;
        else if (thr_we_i) thr_o <= thr_wdata_i;
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |status_o;
    end

    // Per-source threshold compare.
    for (genvar i = 0; i < N_SRC; i++) begin : g_admit
        assign admit[i] = (prio_i[i] <= thr_o);
    end

    assign pending  = (latch_o & cap_i) | (line_i & ~cap_i);
    assign status_o = pending & mask_o & admit;

    ivc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .elig_i (status_o),
        .prio_i (prio_i),
        .win_o  (cur_o)
    );

    p_mask_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
    p_mask_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i) |=> ((mask_o & $past(wdata_i)) == '0));
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_re_i |=> ((latch_o & ~$past(line_i & cap_i)) == '0));
    p_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_o) |-> status_o[cur_o]);
    p_req_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_o) |=> req_o);
    p_req_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |=> !req_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the controller, with the shared per-source controls, register decode and two banks.
// Bank 0 drives irq_o and bank 1 drives fiq_o. Assumes N_SRC <= DATA_W and that N_SRC
// priority words fit within 0x300..0x37F.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IW    = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [11:0]       bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [N_SRC-1:0]             keep_q;
    logic [N_SRC-1:0]             cap_q;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [N_SRC-1:0]             line;
    logic                         wr_s, rd_s, prio_hit;
    logic [IW-1:0]                prio_idx;
    logic [7:0]                   ofs;

    logic [N_SRC-1:0]  mask_b   [NUM_BANKS];
    logic [N_SRC-1:0]  latch_b  [NUM_BANKS];
    logic [PRIO_W-1:0] thr_b    [NUM_BANKS];
    logic [N_SRC-1:0]  status_b [NUM_BANKS];
    logic [IW-1:0]     cur_b    [NUM_BANKS];
    logic              req_b    [NUM_BANKS];

    assign wr_s     = bus_sel_i & bus_wr_i;
    assign rd_s     = bus_sel_i & ~bus_wr_i;
    assign ofs      = bus_addr_i[7:0];
    assign prio_idx = bus_addr_i[2 +: IW];
    assign prio_hit = (bus_addr_i[11:8] == PAGE_PRIO) && (int'(bus_addr_i[7:2]) < int'(N_SRC));
    assign line     = src_i ^ ~keep_q;

    // Shared polarity and capture-mode words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '1;
            cap_q  <= '0;
        end else if (wr_s && bus_addr_i == ADR_POL) begin
            keep_q <= bus_wdata_i[N_SRC-1:0];
        end else if (wr_s && bus_addr_i == ADR_CAP) begin
            cap_q <= bus_wdata_i[N_SRC-1:0];
        end
    end

    // Per-source priority words.
    always_ff @(posedge clk) begin
        if (!rst_n)                prio_q <= '0;
        else if (wr_s && prio_hit) prio_q[prio_idx] <= bus_wdata_i[PRIO_W-1:0];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic page_hit;
        assign page_hit = (bus_addr_i[11:8] == 4'(b));

        ivc_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_i      (line),
            .cap_i       (cap_q),
            .prio_i      (prio_q),
            .set_we_i    (wr_s && page_hit && ofs == OFS_SET),
            .clr_we_i    (wr_s && page_hit && ofs == OFS_CLR),
            .thr_we_i    (wr_s && page_hit && ofs == OFS_THR),
            .ack_re_i    (rd_s && page_hit && ofs == OFS_ACK),
            .wdata_i     (bus_wdata_i[N_SRC-1:0]),
            .thr_wdata_i (bus_wdata_i[PRIO_W-1:0]),
            .mask_o      (mask_b[b]),
            .latch_o     (latch_b[b]),
            .thr_o       (thr_b[b]),
            .status_o    (status_b[b]),
            .cur_o       (cur_b[b]),
            .req_o       (req_b[b])
        );
    end

    assign irq_o = req_b[0];
    assign fiq_o = req_b[1];

    // Read multiplexer, same-cycle data.
    always_comb begin
        bus_rdata_o = '0;
        if (rd_s) begin
            if (bus_addr_i[11:9] == 3'b000) begin
                case (ofs)
                    OFS_STATUS: bus_rdata_o = DATA_W'(status_b[bus_addr_i[8]]);
                    OFS_RAW:    bus_rdata_o = DATA_W'(line);
                    OFS_SET:    bus_rdata_o = DATA_W'(mask_b[bus_addr_i[8]]);
                    OFS_CUR:    bus_rdata_o = DATA_W'(cur_b[bus_addr_i[8]]);
                    OFS_ACK:    bus_rdata_o = DATA_W'(latch_b[bus_addr_i[8]]);
                    OFS_THR:    bus_rdata_o = DATA_W'(thr_b[bus_addr_i[8]]);
                    default:    bus_rdata_o = '0;
                endcase
            end else if (bus_addr_i == ADR_POL) begin
                bus_rdata_o = DATA_W'(keep_q);
            end else if (bus_addr_i == ADR_CAP) begin
                bus_rdata_o = DATA_W'(cap_q);
            end else if (prio_hit) begin
                bus_rdata_o = DATA_W'(prio_q[prio_idx]);
            end
        end
    end
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // Behavioural model state
    logic [31:0] m_keep, m_cap;
    int          m_prio [32];
    logic [31:0] m_mask [2], m_latch [2];
    int          m_thr [2];
    logic        m_out [2];

    task automatic m_reset();
        m_keep = '1; m_cap = '0;
        foreach (m_prio[i]) m_prio[i] = 0;
        for (int b = 0; b < 2; b++) begin
            m_mask[b] = '0; m_latch[b] = '0; m_thr[b] = 15; m_out[b] = 1'b0;
        end
    endtask

    function automatic logic [31:0] f_line();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = m_keep[i] ? src[i] : !src[i];
        return v;
    endfunction

    function automatic logic [31:0] f_stat(int b);
        logic [31:0] ln = f_line();
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++) begin
            logic p = m_cap[i] ? m_latch[b][i] : ln[i];
            if (p && m_mask[b][i] && m_prio[i] <= m_thr[b]) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic int f_cur(int b);
        logic [31:0] s = f_stat(b);
        int best = 99, id = 0;
        for (int i = 0; i < 32; i++)
            if (s[i] && m_prio[i] < best) begin best = m_prio[i]; id = i; end
        return id;
    endfunction

    function automatic logic [31:0] f_read(logic [11:0] a);
        int b = a[8];
        if (a[11:9] == 0) begin
            case (a[7:0])
                8'h00: return f_stat(b);
                8'h04: return f_line();
                8'h08: return m_mask[b];
                8'h20: return 32'(f_cur(b));
                8'h28: return m_latch[b];
                8'h2C: return 32'(m_thr[b]);
                default: return '0;
            endcase
        end
        if (a == 12'h200) return m_keep;
        if (a == 12'h204) return m_cap;
        if (a[11:8] == 3 && a[7] == 0) return 32'(m_prio[a[6:2]]);
        return '0;
    endfunction

    function automatic string f_tag(logic [11:0] a);
        if (a == 12'h200) return "R2";
        if (a == 12'h204) return "R3";
        if (a[11:8] == 3) return "R8";
        case (a[7:0])
            8'h00: return "R5";
            8'h04: return "R2";
            8'h20: return "R6";
            8'h28: return "R4";
            8'h2C: return "R7";
            default: return "R1";
        endcase
    endfunction

    // Model step at a clock edge, all next values taken from present values
    task automatic m_edge();
        logic [31:0] ln = f_line();
        logic [31:0] nl [2];
        logic        no [2];
        if (!rst_n) begin m_reset(); return; end
        for (int b = 0; b < 2; b++) begin
            no[b] = (f_stat(b) != 0);
            nl[b] = m_latch[b];
            if (sel && !wr && addr[11:9] == 0 && addr[8] == b[0] && addr[7:0] == 8'h28) nl[b] = '0;
            nl[b] = nl[b] | (ln & m_cap);
        end
        for (int b = 0; b < 2; b++) begin
            m_out[b] = no[b]; m_latch[b] = nl[b];
        end
        if (sel && wr) begin
            if (addr[11:9] == 0) begin
                case (addr[7:0])
                    8'h08: m_mask[addr[8]] = m_mask[addr[8]] | wdata;
                    8'h0C: m_mask[addr[8]] = m_mask[addr[8]] & ~wdata;
                    8'h2C: m_thr[addr[8]] = int'(wdata[3:0]);
                    default: ;
                endcase
            end else if (addr == 12'h200) m_keep = wdata;
            else if (addr == 12'h204) m_cap = wdata;
            else if (addr[11:8] == 3 && addr[7] == 0) m_prio[addr[6:2]] = int'(wdata[3:0]);
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // One bus cycle; entered and left at a falling edge
    task automatic step(logic s, logic w, logic [11:0] a, logic [31:0] d, string tag);
        sel = s; wr = w; addr = a; wdata = d;
        #1;
        chk((tag == "R10") ? "R10" : "R9", {31'b0, irq}, {31'b0, m_out[0]});
        chk((tag == "R10") ? "R10" : "R9", {31'b0, fiq}, {31'b0, m_out[1]});
        if (s && !w) chk((tag == "") ? f_tag(a) : tag, rdata, f_read(a));
        @(posedge clk);
        m_edge();
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, string tag = ""); step(1'b1, 1'b0, a, '0, tag); endtask
    task automatic wrr(logic [11:0] a, logic [31:0] d); step(1'b1, 1'b1, a, d, ""); endtask
    task automatic idle(); step(1'b0, 1'b0, '0, '0, ""); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_reset();
        @(negedge clk);
        repeat (3) step(1'b0, 1'b0, '0, '0, "R10");
        rst_n = 1'b1;
        // R10: reset state
        rd(12'h008, "R10"); rd(12'h108, "R10"); rd(12'h028, "R10"); rd(12'h314, "R10");
        // R7: thresholds admit all after reset
        rd(12'h02C); rd(12'h12C);
        // R2: polarity selection on raw view
        src = 32'h0000_00A5; rd(12'h004);
        wrr(12'h200, 32'hFFFF_FF0F); rd(12'h004); rd(12'h104); rd(12'h200);
        wrr(12'h200, 32'hFFFF_FFFF);
        // R1: set/clear mask
        wrr(12'h008, 32'h0000_00FF); wrr(12'h00C, 32'h0000_000F); rd(12'h008); rd(12'h00C);
        wrr(12'h108, 32'h0000_0F00); rd(12'h108);
        // R8/R6: priorities and winner
        wrr(12'h314, 3); wrr(12'h31C, 3); wrr(12'h318, 1); rd(12'h318);
        src = 32'h0000_00E0; idle(); rd(12'h000); rd(12'h020);
        src = 32'h0000_00A0; idle(); rd(12'h020);
        // R7: threshold excludes
        wrr(12'h02C, 2); rd(12'h000); rd(12'h020); idle(); wrr(12'h02C, 15); idle();
        // Fast bank winner
        src = 32'h0000_0330; wrr(12'h324, 0); rd(12'h120); rd(12'h100); idle();
        // R3/R4: latched mode and acknowledge
        src = 32'h0; wrr(12'h204, 32'h0000_0010); wrr(12'h008, 32'h10); wrr(12'h108, 32'h10);
        src = 32'h0000_0010; idle(); src = 32'h0; idle(); idle();
        rd(12'h000); rd(12'h100);
        rd(12'h128); rd(12'h100); rd(12'h000);
        rd(12'h028); rd(12'h000); idle();
        // Acknowledge while line still asserted
        src = 32'h0000_0010; idle(); rd(12'h028); src = 32'h0; rd(12'h000);
        rd(12'h028); rd(12'h000); idle(); idle();
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            logic [11:0] a;
            int pick = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) src = $urandom();
            case (pick)
                0, 1, 2, 3, 4: a = {3'b0, 1'($urandom_range(0, 1)), 8'(4 * $urandom_range(0, 11))};
                5: a = 12'h200;
                6: a = 12'h204;
                default: a = 12'h300 + 12'(4 * $urandom_range(0, 31));
            endcase
            if (a == 12'h200 && $urandom_range(0, 1) == 0) step(1'b1, 1'b1, a, 32'hFFFF_FFFF, "");
            else step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, $urandom(), "");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule